// File: doc/BRIEF.md
# Low-Frequency Tag Gap-Modulated Command Sender

This block drives the carrier-enable line of a 125 kHz reader so that it sends commands to a passive tag. The carrier is switched off for short fixed gaps, and each bit is carried by the length of the carrier-on stretch that follows. All timing is counted in field clocks, where one field clock is one carrier period. A built-in divider makes the field clock from the system clock and restarts at every accepted command. A parameter can select an external tick input instead.

A command is started with a one-cycle strobe, together with a command code, a password-enable flag, a 32-bit password, 32-bit data and a 3-bit block address. The block builds the frame for that command and sends it. It then either holds the carrier for the tag's programming time and switches it off (write), or waits out a settling interval and opens the receive window while the carrier stays on (read, trace and wake). A one-cycle completion pulse marks the end of each command.

Top module: `lf_gap_downlink`

## Requirements
- R1: An accepted command first drives `field_o` low for exactly START_GAP field clocks (default 31).
- R2: A frame bit 0 is sent as `field_o` high for BIT0_ON field clocks (default 18) and a bit 1 as high for BIT1_ON field clocks (default 50). Consecutive bits are separated by `field_o` low for WRITE_GAP field clocks (default 20).
- R3: `cmd_i` encodes 0 = write, 1 = read, 2 = trace, 3 = wake. Every frame begins with the two bits 1,0, except trace, which sends 1,1 and nothing more.
- R4: The 32-bit password follows the leading two bits, most significant bit first. It is sent for a write or a read when `pwd_en_i` is 1, and it is always sent for a wake.
- R5: A write continues with a 0 lock bit, then `data_i` most significant bit first, then `addr_i` most significant bit first.
- R6: A read continues with one 0 separator bit and then `addr_i` most significant bit first. A wake sends neither the separator nor the address.
- R7: After the last bit of a write, `field_o` stays high for PROG_HOLD further field clocks. It then goes low in the same cycle that `done_o` pulses.
- R8: After the last bit of a read, trace or wake, `field_o` stays high. After READ_GAP field clocks (default 52), `done_o` pulses and `rx_open_o` goes high. Both the carrier and `rx_open_o` stay high until the next accepted start, which clears `rx_open_o`.
- R9: With USE_EXT_TICK = 0, one field clock lasts TICK_DIV system clocks (default 192), counted from the accepted start. With USE_EXT_TICK = 1, `tick_i` is the field-clock strobe.
- R10: `start_i` has no effect while `busy_o` is high.
- R11: `busy_o` is high from the cycle after an accepted start until the cycle in which `done_o` pulses. `done_o` is high for exactly one system clock.
- R12: During and after reset, `field_o`, `busy_o`, `done_o` and `rx_open_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | External field-clock strobe, used when USE_EXT_TICK = 1 |
| start_i | input | 1 | Command start strobe |
| cmd_i | input | 2 | Command code: 0 write, 1 read, 2 trace, 3 wake |
| pwd_en_i | input | 1 | Send the password with a write or a read |
| pwd_i | input | 32 | Password |
| data_i | input | 32 | Write data |
| addr_i | input | 3 | Block address |
| field_o | output | 1 | Carrier enable |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rx_open_o | output | 1 | Receive window open |

## Verification
On every cycle, the assertions check the following:
- a new command starts with the carrier off;
- inter-bit gaps keep the carrier off;
- the fall of busy coincides with a single-cycle done pulse;
- a write completes with the carrier off;
- an open receive window always has the carrier on;
- a start strobe during a command leaves the sequencer state unchanged.

Only the bench scenarios can show that the frame content is right: the bit order, which fields appear for each command and password setting, and the exact run lengths in field clocks. The bench recovers these by decoding the length of every carrier-on and carrier-off run at the output.

// File: rtl/lfgd_pkg.sv
package lfgd_pkg;
  localparam int PWD_W   = 32;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 3;
  localparam int FRAME_W = 2 + PWD_W + 1 + DATA_W + ADDR_W;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    CMD_WRITE = 2'd0,
    CMD_READ  = 2'd1,
    CMD_TRACE = 2'd2,
    CMD_WAKE  = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SGAP, ST_BON, ST_BGAP, ST_HOLD, ST_RGAP, ST_LISTEN
  } st_e;
endpackage

// File: rtl/lfgd_tick.sv
module lfgd_tick #(
  parameter int TICK_DIV     = 192,
  parameter bit USE_EXT_TICK = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic ext_tick_i,
  output logic tick_o
);
  localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);

  logic [DW-1:0] cnt_q;
  logic          div_tick;

  assign div_tick = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (div_tick) cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  always_comb tick_o = USE_EXT_TICK ? ext_tick_i : div_tick;

  // R9
  div_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  // R9
  div_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (TICK_DIV > 1 && div_tick) |=> !div_tick);
endmodule

// File: rtl/lfgd_frame.sv
module lfgd_frame
  import lfgd_pkg::*;
(
  input  cmd_e                cmd_i,
  input  logic                pwd_en_i,
  input  logic [PWD_W-1:0]    pwd_i,
  input  logic [DATA_W-1:0]   data_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [FRAME_W-1:0]  frame_o,
  output logic [LEN_W-1:0]    len_o
);
  // frame is left aligned: first bit on the wire is frame_o[FRAME_W-1]
  always_comb begin
    frame_o = '0;
    len_o   = '0;
    unique case (cmd_i)
      CMD_WRITE: begin
        if (pwd_en_i) begin
          frame_o = {2'b10, pwd_i, 1'b0, data_i, addr_i};
          len_o   = LEN_W'(2 + PWD_W + 1 + DATA_W + ADDR_W);
        end else begin
          frame_o = {2'b10, 1'b0, data_i, addr_i, {PWD_W{1'b0}}};
          len_o   = LEN_W'(2 + 1 + DATA_W + ADDR_W);
        end
      end
      CMD_READ: begin
        if (pwd_en_i) begin
          frame_o = {2'b10, pwd_i, 1'b0, addr_i, {DATA_W{1'b0}}};
          len_o   = LEN_W'(2 + PWD_W + 1 + ADDR_W);
        end else begin
          frame_o = {2'b10, 1'b0, addr_i, {(PWD_W + DATA_W){1'b0}}};
          len_o   = LEN_W'(2 + 1 + ADDR_W);
        end
      end
      CMD_WAKE: begin
        frame_o = {2'b10, pwd_i, {(1 + DATA_W + ADDR_W){1'b0}}};
        len_o   = LEN_W'(2 + PWD_W);
      end
      default: begin
        frame_o = {2'b11, {(FRAME_W - 2){1'b0}}};
        len_o   = LEN_W'(2);
      end
    endcase
  end
endmodule

// File: rtl/lfgd_seq.sv
module lfgd_seq
  import lfgd_pkg::*;
#(
  parameter int START_GAP = 31,
  parameter int WRITE_GAP = 20,
  parameter int BIT0_ON   = 18,
  parameter int BIT1_ON   = 50,
  parameter int PROG_HOLD = 2500,
  parameter int READ_GAP  = 52
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               start_i,
  input  cmd_e               cmd_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [LEN_W-1:0]   len_i,
  output logic               accept_o,
  output logic               field_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               rx_open_o
);
  localparam int TMAX = START_GAP + WRITE_GAP + BIT0_ON + BIT1_ON + PROG_HOLD + READ_GAP;
  localparam int TW   = $clog2(TMAX + 1);

  st_e                st_q;
  logic [TW-1:0]      tmr_q;
  logic [FRAME_W-1:0] frame_q;
  logic [LEN_W-1:0]   left_q;
  logic               wr_q, field_q, done_q, rx_q;

  function automatic logic [TW-1:0] on_len(input logic b);
    return b ? TW'(BIT1_ON - 1) : TW'(BIT0_ON - 1);
  endfunction

  assign busy_o   = (st_q != ST_IDLE) && (st_q != ST_LISTEN);
  assign accept_o = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      tmr_q   <= '0;
      frame_q <= '0;
      left_q  <= '0;
      wr_q    <= 1'b0;
      field_q <= 1'b0;
      done_q  <= 1'b0;
      rx_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept_o) begin
        st_q    <= ST_SGAP;
        tmr_q   <= TW'(START_GAP - 1);
        frame_q <= frame_i;
        left_q  <= len_i;
        wr_q    <= (cmd_i == CMD_WRITE);
        field_q <= 1'b0;
        rx_q    <= 1'b0;
      end else if (tick_i && busy_o) begin
        if (tmr_q != '0) begin
          tmr_q <= tmr_q - 1'b1;
        end else begin
          unique case (st_q)
            ST_SGAP, ST_BGAP: begin
              st_q    <= ST_BON;
              field_q <= 1'b1;
              tmr_q   <= on_len(frame_q[FRAME_W-1]);
            end
            ST_BON: begin
              if (left_q == LEN_W'(1)) begin
                st_q  <= wr_q ? ST_HOLD : ST_RGAP;
                tmr_q <= wr_q ? TW'(PROG_HOLD - 1) : TW'(READ_GAP - 1);
              end else begin
                st_q    <= ST_BGAP;
                field_q <= 1'b0;
                tmr_q   <= TW'(WRITE_GAP - 1);
                frame_q <= frame_q << 1;
                left_q  <= left_q - 1'b1;
              end
            end
            ST_HOLD: begin
              st_q    <= ST_IDLE;
              field_q <= 1'b0;
              done_q  <= 1'b1;
            end
            ST_RGAP: begin
              st_q   <= ST_LISTEN;
              rx_q   <= 1'b1;
              done_q <= 1'b1;
            end
            default: st_q <= ST_IDLE;
          endcase
        end
      end
    end
  end

  assign field_o   = field_q;
  assign done_o    = done_q;
  assign rx_open_o = rx_q;

  // R1
  cmd_starts_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !field_q);

  // R2
  gap_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BGAP) |-> !field_q);

  // R7
  write_ends_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !rx_q) |-> !field_q);

  // R8
  rx_needs_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_q |-> field_q);

  // R10
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !tick_i) |=> ($stable(left_q) && $stable(tmr_q) && $stable(wr_q)));

  // R11
  busy_end_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_q);

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R3
  frame_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_q <= LEN_W'(FRAME_W));
endmodule

// File: rtl/lf_gap_downlink.sv
module lf_gap_downlink
  import lfgd_pkg::*;
#(
  parameter int TICK_DIV     = 192,
  parameter bit USE_EXT_TICK = 1'b0,
  parameter int START_GAP    = 31,
  parameter int WRITE_GAP    = 20,
  parameter int BIT0_ON      = 18,
  parameter int BIT1_ON      = 50,
  parameter int PROG_HOLD    = 2500,
  parameter int READ_GAP     = 52
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic [1:0]        cmd_i,
  input  logic              pwd_en_i,
  input  logic [PWD_W-1:0]  pwd_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              field_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              rx_open_o
);
  cmd_e               cmd;
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   len;
  logic               tick, accept;

  assign cmd = cmd_e'(cmd_i);

  lfgd_tick #(.TICK_DIV(TICK_DIV), .USE_EXT_TICK(USE_EXT_TICK)) u_tick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (accept),
    .ext_tick_i (tick_i),
    .tick_o     (tick)
  );

  lfgd_frame u_frame (
    .cmd_i    (cmd),
    .pwd_en_i (pwd_en_i),
    .pwd_i    (pwd_i),
    .data_i   (data_i),
    .addr_i   (addr_i),
    .frame_o  (frame),
    .len_o    (len)
  );

  lfgd_seq #(
    .START_GAP (START_GAP),
    .WRITE_GAP (WRITE_GAP),
    .BIT0_ON   (BIT0_ON),
    .BIT1_ON   (BIT1_ON),
    .PROG_HOLD (PROG_HOLD),
    .READ_GAP  (READ_GAP)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .start_i   (start_i),
    .cmd_i     (cmd),
    .frame_i   (frame),
    .len_i     (len),
    .accept_o  (accept),
    .field_o   (field_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .rx_open_o (rx_open_o)
  );
endmodule

// File: tb/lf_gap_downlink_test.sv
`timescale 1ns/1ps
module lf_gap_downlink_test;
  localparam int DIV  = 4;
  localparam int SG   = 31;
  localparam int WG   = 20;
  localparam int B0   = 18;
  localparam int B1   = 50;
  localparam int HOLD = 60;
  localparam int RG   = 52;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  cmd_i = 2'd0;
  logic        pwd_en_i = 1'b0;
  logic [31:0] pwd_i = '0;
  logic [31:0] data_i = '0;
  logic [2:0]  addr_i = '0;
  logic        field_o, busy_o, done_o, rx_open_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc_total = 0;

  bit exp_b [0:79];
  int n_exp;
  int runs [0:199];
  int n_runs;

  lf_gap_downlink #(
    .TICK_DIV(DIV), .USE_EXT_TICK(1'b0), .START_GAP(SG), .WRITE_GAP(WG),
    .BIT0_ON(B0), .BIT1_ON(B1), .PROG_HOLD(HOLD), .READ_GAP(RG)
  ) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .start_i(start_i),
    .cmd_i(cmd_i), .pwd_en_i(pwd_en_i), .pwd_i(pwd_i), .data_i(data_i),
    .addr_i(addr_i), .field_o(field_o), .busy_o(busy_o), .done_o(done_o),
    .rx_open_o(rx_open_o)
  );

  always #4 clk_i = ~clk_i;

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  always @(posedge clk_i) begin
    cyc_total++;
    if (cyc_total > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected < 190000", cyc_total);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
    end
  endtask

  task automatic push(input bit b);
    exp_b[n_exp] = b;
    n_exp++;
  endtask

  // cmd: 0 write, 1 read, 2 trace, 3 wake
  task automatic run_cmd(input logic [1:0] c, input logic pe, input logic [31:0] pw,
                         input logic [31:0] dt, input logic [2:0] ad, input bit poke,
                         input string tag);
    int cur, len, cyc, nbits, bad_gap, bad_bit, extra, v;
    bit got;
    n_exp = 0;
    push(1'b1);
    push(c == 2'd2);
    if (c != 2'd2) begin
      if (c == 2'd3 || pe) for (int i = 31; i >= 0; i--) push(pw[i]);
      if (c == 2'd0) begin
        push(1'b0);
        for (int i = 31; i >= 0; i--) push(dt[i]);
        for (int i = 2; i >= 0; i--) push(ad[i]);
      end else if (c == 2'd1) begin
        push(1'b0);
        for (int i = 2; i >= 0; i--) push(ad[i]);
      end
    end

    @(negedge clk_i);
    cmd_i = c; pwd_en_i = pe; pwd_i = pw; data_i = dt; addr_i = ad; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o == 1'b1, {tag, " R11 busy after start"}, busy_o, 1);
    chk(rx_open_o == 1'b0, {tag, " R8 rx window cleared by start"}, rx_open_o, 0);
    chk(field_o == 1'b0, {tag, " R1 first level low"}, field_o, 0);
    n_runs = 0; cur = field_o; len = 1; cyc = 0;
    forever begin
      @(negedge clk_i);
      cyc++;
      if (poke) begin
        if (cyc == 500) begin start_i = 1'b1; cmd_i = 2'd2; pwd_en_i = 1'b0; end
        if (cyc == 501) start_i = 1'b0;
      end
      if (done_o || cyc > 40000) break;
      if (field_o == cur) len++;
      else begin
        if (n_runs < 200) runs[n_runs] = len;
        n_runs++; cur = field_o; len = 1;
      end
    end
    if (n_runs < 200) runs[n_runs] = len;
    n_runs++;

    chk(done_o == 1'b1, {tag, " R11 done seen"}, done_o, 1);
    chk(runs[0] == SG * DIV, {tag, " R1 R9 start gap cycles"}, runs[0], SG * DIV);
    nbits = n_runs / 2;
    chk(nbits == n_exp && (n_runs % 2) == 0, {tag, " R3 bit count"}, nbits, n_exp);
    bad_gap = 0; bad_bit = 0;
    if (nbits == n_exp && n_runs <= 200) begin
      for (int k = 2; k < n_runs; k += 2) if (runs[k] != WG * DIV) bad_gap++;
      for (int j = 0; j < nbits; j++) begin
        extra = (j == nbits - 1) ? ((c == 2'd0) ? HOLD * DIV : RG * DIV) : 0;
        v = runs[2 * j + 1] - extra;
        if (v == B1 * DIV) got = 1'b1;
        else if (v == B0 * DIV) got = 1'b0;
        else begin got = ~exp_b[j]; end
        if (got != exp_b[j]) bad_bit++;
      end
    end else begin
      bad_gap = 1; bad_bit = 1;
    end
    chk(bad_gap == 0, {tag, " R2 gap lengths"}, bad_gap, 0);
    chk(bad_bit == 0, {tag, " R2 bit values"}, bad_bit, 0);
    if (c == 2'd0) begin
      chk(field_o == 1'b0 && busy_o == 1'b0 && rx_open_o == 1'b0,
          {tag, " R7 carrier off at write end"}, {field_o, busy_o, rx_open_o}, 0);
    end else begin
      chk(field_o == 1'b1 && busy_o == 1'b0 && rx_open_o == 1'b1,
          {tag, " R8 window open, carrier on"}, {field_o, busy_o, rx_open_o}, 3'b101);
    end
    @(negedge clk_i);
    chk(done_o == 1'b0, {tag, " R11 done one cycle"}, done_o, 0);
    repeat (20) @(negedge clk_i);
    chk(field_o == (c != 2'd0), {tag, " R8 carrier level holds"}, field_o, c != 2'd0);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk({field_o, busy_o, done_o, rx_open_o} == 4'b0, "R12 reset outputs",
        {field_o, busy_o, done_o, rx_open_o}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk({field_o, busy_o, done_o, rx_open_o} == 4'b0, "R12 idle after reset",
        {field_o, busy_o, done_o, rx_open_o}, 0);
  endtask

  // R4 R5: write with password
  task automatic t_write_pwd();
    run_cmd(2'd0, 1'b1, 32'hA5C3_0F81, 32'h8000_0001, 3'd6, 1'b0, "R4 R5 write+pwd");
  endtask

  // R5: write without password
  task automatic t_write_plain();
    run_cmd(2'd0, 1'b0, 32'hFFFF_FFFF, 32'h1234_5678, 3'd5, 1'b0, "R5 write");
  endtask

  // R4 R6: read with password
  task automatic t_read_pwd();
    run_cmd(2'd1, 1'b1, 32'h0000_0003, 32'hDEAD_BEEF, 3'd1, 1'b0, "R4 R6 read+pwd");
  endtask

  // R6: plain read, address 7
  task automatic t_read_plain();
    run_cmd(2'd1, 1'b0, 32'hFFFF_FFFF, 32'h0, 3'd7, 1'b0, "R6 read");
  endtask

  // R4 R6: wake always sends password, no address
  task automatic t_wake();
    run_cmd(2'd3, 1'b0, 32'hC001_D00D, 32'h0, 3'd4, 1'b0, "R4 R6 wake");
  endtask

  // R3: trace sends opcode only
  task automatic t_trace();
    run_cmd(2'd2, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'd3, 1'b0, "R3 trace");
  endtask

  // R10: start pulse mid-write must not disturb the frame
  task automatic t_busy_ignore();
    run_cmd(2'd0, 1'b0, 32'h0, 32'h0F0F_00FF, 3'd2, 1'b1, "R10 start while busy");
  endtask

  initial begin
    t_reset();
    t_write_pwd();
    t_read_pwd();
    t_trace();
    t_write_plain();
    t_read_plain();
    t_wake();
    t_busy_ignore();
    summary();
    $finish;
  end
endmodule